// File: doc/BRIEF.md
# Shaped Envelope Generator

This block produces a 4-bit amplitude envelope for a tone mixer. A free-running prescaler divides the clock by a fixed ratio, 256 by default. A programmable 16-bit period then divides that again, and each resulting step moves a 4-bit counter one place. Sixteen steps make one envelope cycle. A 4-bit shape code, captured when the envelope is restarted, selects among eight waveforms. These are one-shot ramps, repeating sawtooth ramps, repeating triangles, and ramps that stop at full or zero level.

The mixer block reads `level` as the current envelope amplitude. Software-side register access and the D/A stage are outside this block. The envelope begins a new cycle only on a `restart` pulse, which resets the prescaler, the period counter and the step counter together.

Top module: `env_shape_gen`

## Requirements
- R1: While `rst_n` is low and afterwards until the first `restart`, `level` is 0 and does not move.
- R2: A `restart` sampled high at a clock edge clears the prescaler, period counter and step counter, captures `shape`, and makes `level` 0 if `shape[2]` (Attack) is 1 or 15 if it is 0, from that edge on.
- R3: Counting the restart edge as edge 0, `level` changes only at edges that are multiples of PRESCALE×P, where P is the period. With the defaults, the first change comes at edge 256×P.
- R4: A period of 0 gives the same step timing as a period of 1.
- R5: One cycle is 16 steps. A rising cycle (direction up) shows 0,1,…,15 and a falling cycle shows 15,14,…,0.
- R6: When `shape[3]` (Continue) is 0, the level goes to 0 after the first cycle and stays there, whatever bits 1 and 0 hold.
- R7: With Continue=1, Alternate (`shape[1]`)=0 and Hold (`shape[0]`)=0, each cycle repeats in the same direction (sawtooth).
- R8: With Continue=1, Alternate=1 and Hold=0, the direction reverses at every cycle end (triangle).
- R9: With Continue=1 and Hold=1, the level freezes after the first cycle at that cycle's last value, or at its complement if Alternate=1. So 1011 and 1101 hold 15, and 1001 and 1111 hold 0.
- R10: Once frozen, the level stays fixed until the next `restart`. Changing `shape` without a restart has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Single-cycle pulse that starts a new envelope with the present shape |
| period | input | 16 | Step period in prescaled ticks, 0 read as 1 |
| shape | input | 4 | [3] Continue, [2] Attack, [1] Alternate, [0] Hold |
| level | output | 4 | Current envelope amplitude |

## Verification
The level is decoded directly from state registers, so a restart shows its start value in the half-cycle after the restart edge. Step k shows from edge PRESCALE×P×k onward. The bench counts edges from the restart edge and samples on falling edges. It takes each step in the middle of its window, or one edge either side of a boundary when the boundary itself is under test. A second instance with the full 256 prescale is probed one edge before and at the first step edge to pin down the exact step timing.

// File: rtl/env_pkg.sv
package env_pkg;
   typedef struct packed {
      logic cont;
      logic attack;
      logic alt;
      logic hold;
   } env_shape_t;
endpackage

// File: rtl/env_prescaler.sv
module env_prescaler #(
   parameter int DIV = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad
         $error("env_prescaler: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_cnt
         logic [CNT_W-1:0] cnt;
         assign tick = (cnt == CNT_W'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (clr)   cnt <= '0;
            else if (tick)  cnt <= '0;
            else            cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/env_period_ctr.sv
module env_period_ctr #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [PER_W-1:0] period,
   output logic             step
);
   logic [PER_W-1:0] pcnt;
   logic [PER_W-1:0] eff;

   assign eff  = (period == '0) ? PER_W'(1) : period;
   assign step = tick && (pcnt >= eff - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pcnt <= '0;
      else if (clr)  pcnt <= '0;
      else if (tick) pcnt <= step ? '0 : pcnt + 1'b1;
   end
endmodule

// File: rtl/env_shaper.sv
module env_shaper
   import env_pkg::*;
#(
   parameter int LVL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             step,
   input  env_shape_t       shape_in,
   output logic [LVL_W-1:0] level,
   output logic             held_o,
   output logic             cont_o
);
   localparam logic [LVL_W-1:0] TOP = '1;

   env_shape_t       shape_q;
   logic [LVL_W-1:0] cnt;
   logic             dir_up;
   logic             held;
   logic [LVL_W-1:0] hold_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shape_q  <= '0;
         cnt      <= '0;
         dir_up   <= 1'b0;
         held     <= 1'b1;
         hold_val <= '0;
      end else if (restart) begin
         shape_q  <= shape_in;
         cnt      <= '0;
         dir_up   <= shape_in.attack;
         held     <= 1'b0;
      end else if (step && !held) begin
         if (cnt == TOP) begin
            if (!shape_q.cont) begin
               held     <= 1'b1;
               hold_val <= '0;
            end else if (shape_q.hold) begin
               held     <= 1'b1;
               hold_val <= (dir_up ^ shape_q.alt) ? TOP : '0;
            end else begin
               cnt    <= '0;
               dir_up <= dir_up ^ shape_q.alt;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign level  = held ? hold_val : (dir_up ? cnt : ~cnt);
   assign held_o = held;
   assign cont_o = shape_q.cont;
endmodule

// File: rtl/env_shape_gen.sv
module env_shape_gen
   import env_pkg::*;
#(
   parameter int PRESCALE = 256,
   parameter int PER_W    = 16,
   parameter int LVL_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [PER_W-1:0] period,
   input  logic [3:0]       shape,
   output logic [LVL_W-1:0] level
);
   generate
      if (PER_W < 1) begin : g_bad_per
         $error("env_shape_gen: PER_W must be at least 1");
      end
      if (LVL_W < 1) begin : g_bad_lvl
         $error("env_shape_gen: LVL_W must be at least 1");
      end
   endgenerate

   logic tick_w;
   logic step_w;
   logic held_w;
   logic cont_w;

   env_prescaler #(.DIV(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(restart), .tick(tick_w)
   );

   env_period_ctr #(.PER_W(PER_W)) u_per (
      .clk(clk), .rst_n(rst_n), .clr(restart), .tick(tick_w),
      .period(period), .step(step_w)
   );

   env_shaper #(.LVL_W(LVL_W)) u_shp (
      .clk(clk), .rst_n(rst_n), .restart(restart), .step(step_w),
      .shape_in(env_shape_t'(shape)), .level(level),
      .held_o(held_w), .cont_o(cont_w)
   );
endmodule

// File: rtl/env_shape_gen_chk.sv
module env_shape_gen_chk #(
   parameter int LVL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             restart,
   input logic [3:0]       shape,
   input logic [LVL_W-1:0] level,
   input logic             tick,
   input logic             step,
   input logic             held,
   input logic             cont_q
);
   // R2: restart sets the start level from Attack
   a_r2_restart_level: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (level == (shape[2] ? LVL_W'(0) : {LVL_W{1'b1}})));

   // R3: the level only moves on a step or a restart
   a_r3_quiet_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !step) |=> $stable(level));

   // R3: a step can only come on a prescaler tick
   a_r3_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> tick);

   // R10: a frozen level stays put until restart
   a_r10_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !restart) |=> $stable(level));

   // R6: one-shot shapes rest at zero
   a_r6_oneshot_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !cont_q) |-> (level == '0));
endmodule

bind env_shape_gen env_shape_gen_chk #(.LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .restart(restart), .shape(shape),
   .level(level), .tick(tick_w), .step(step_w), .held(held_w),
   .cont_q(cont_w)
);

// File: tb/test_env_shape_gen.sv
module test_env_shape_gen;
   localparam int CLK_PERIOD = 10;
   localparam int PRE_SMALL  = 8;
   localparam int NROWS      = 16;
   localparam int NSAMP      = 8;

   // steps sampled for each row, in nibble order of the expected word
   localparam int SAMP_STEP [NSAMP] = '{0, 5, 15, 16, 20, 31, 32, 47};

   // {shape, period, expected levels packed msb-first}
   localparam logic [3:0]  ROW_SHAPE [NROWS] = '{
      4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b0111,
      4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1101, 4'b1110, 4'b1111};
   localparam logic [15:0] ROW_PER [NROWS] = '{
      16'd1, 16'd2, 16'd0, 16'd3, 16'd1, 16'd2, 16'd1, 16'd3,
      16'd1, 16'd2, 16'd1, 16'd0, 16'd1, 16'd2, 16'd1, 16'd3};
   localparam logic [31:0] ROW_EXP [NROWS] = '{
      32'hFA000000, 32'hFA000000, 32'hFA000000, 32'hFA000000,
      32'h05F00000, 32'h05F00000, 32'h05F00000, 32'h05F00000,
      32'hFA0FB0F0, 32'hFA000000, 32'hFA004FF0, 32'hFA0FFFFF,
      32'h05F04F0F, 32'h05FFFFFF, 32'h05FFB00F, 32'h05F00000};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        restart = 1'b0;
   logic [15:0] period = 16'd1;
   logic [3:0]  shape = 4'd0;
   logic [3:0]  level;
   logic [3:0]  level_full;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   env_shape_gen #(.PRESCALE(PRE_SMALL)) i_env_shape_gen (
      .clk(clk), .rst_n(rst_n), .restart(restart), .period(period),
      .shape(shape), .level(level)
   );

   env_shape_gen i_env_full (
      .clk(clk), .rst_n(rst_n), .restart(restart), .period(period),
      .shape(shape), .level(level_full)
   );

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: level got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // restart pulse; returns half a cycle after the restart edge (edge 0)
   task automatic do_restart(input logic [3:0] s, input logic [15:0] p);
      @(negedge clk);
      shape   = s;
      period  = p;
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 in reset", level, 4'd0);
      rst_n = 1'b1;
      repeat (300) @(negedge clk);
      check("R1 idle after reset", level, 4'd0);
      check("R1 idle after reset full", level_full, 4'd0);

      // table walk: R5..R9 and R4 via period-0 rows
      for (int r = 0; r < NROWS; r++) begin
         int pe;
         int elapsed;
         pe = (ROW_PER[r] == 16'd0) ? 1 : int'(ROW_PER[r]);
         do_restart(ROW_SHAPE[r], ROW_PER[r]);
         elapsed = 0;
         for (int k = 0; k < NSAMP; k++) begin
            int tgt;
            tgt = PRE_SMALL * pe * SAMP_STEP[k] + PRE_SMALL / 2;
            repeat (tgt - elapsed) @(negedge clk);
            elapsed = tgt;
            check($sformatf("R5-shape%0b R6 R7 R8 R9 step%0d", ROW_SHAPE[r], SAMP_STEP[k]),
                  level, ROW_EXP[r][31-4*k -: 4]);
         end
      end

      // R3: exact boundary with small prescale, period 3
      do_restart(4'b1100, 16'd3);
      repeat (23) @(negedge clk);
      check("R3 before first step", level, 4'd0);
      @(negedge clk);
      check("R3 at first step", level, 4'd1);

      // R3: full 256 prescale, period 2
      do_restart(4'b1100, 16'd2);
      repeat (511) @(negedge clk);
      check("R3 full before step", level_full, 4'd0);
      @(negedge clk);
      check("R3 full at step", level_full, 4'd1);

      // R4: period 0 with full prescale
      do_restart(4'b1100, 16'd0);
      repeat (255) @(negedge clk);
      check("R4 period0 before step", level_full, 4'd0);
      @(negedge clk);
      check("R4 period0 at step", level_full, 4'd1);

      // R2: restart in mid-cycle
      do_restart(4'b1100, 16'd1);
      repeat (PRE_SMALL * 7 + 4) @(negedge clk);
      check("R2 mid-ramp", level, 4'd7);
      do_restart(4'b0000, 16'd1);
      check("R2 restart falling start", level, 4'd15);
      repeat (PRE_SMALL - 2) @(negedge clk);
      check("R2 counters cleared", level, 4'd15);
      repeat (2) @(negedge clk);
      check("R2 first step after restart", level, 4'd14);

      // R10: frozen hold ignores shape changes without restart
      do_restart(4'b1011, 16'd1);
      repeat (PRE_SMALL * 16 + 10) @(negedge clk);
      check("R10 held at 15", level, 4'd15);
      shape = 4'b0100;
      repeat (200) @(negedge clk);
      check("R10 shape change ignored", level, 4'd15);
      do_restart(4'b0100, 16'd1);
      check("R10 released by restart", level, 4'd0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule